// File: doc/BRIEF.md
# Debug Port Mailbox with Ownership Flag

This block is a serial test access port through which an external debugger and an on-chip processor pass 32-bit words to each other. A 4-bit instruction register chooses what the serial data path reaches: a bypass bit, a small status word, or a shared mailbox word. Loading a dedicated instruction through TDI raises an interrupt to the processor. From then on, one ready flag decides who owns the mailbox. The serial side may load the mailbox only while the flag is 1, and that load clears the flag. The processor then reads or writes the mailbox and hands it back by writing 1 to the flag. Both sides poll the flag: the processor over its register port and the debugger by scanning the status word out on TDO.

The serial pins are oversampled by the system clock through a two-flop synchroniser, so the whole block runs in one clock domain. The TAP state machine moves on each detected rising edge of TCK, and TDO changes on each detected falling edge. An illegal load of the mailbox from either side leaves the mailbox unchanged and sets a sticky error bit.

Top module: `dbg_mailbox`

## Requirements
- R1: After system reset the processor reads the status word (cpuAddr=0) as 0x1, with ready flag bit 0 = 1, pending bit 1 = 0 and error bit 2 = 0, and irq is low.
- R2: An instruction scan that updates the instruction register to 4'b1010 sets the pending bit and drives irq high.
- R3: irq stays high until the processor writes status with bit 1 = 1. That write drops irq and clears the pending bit.
- R4: With instruction 4'b0110 loaded, a data scan shifts out an 8-bit status word, LSB first, captured in Capture-DR as {5'b0, error, pending, flag}.
- R5: With instruction 4'b0111 loaded and the flag at 1, a 32-bit data scan (shifted in LSB first) is written into the mailbox in Update-DR and the flag clears to 0.
- R6: In Capture-DR with instruction 4'b0111, the current mailbox value is loaded and shifted out on TDO, LSB first.
- R7: While the flag is 0, a processor write to cpuAddr=1 updates the mailbox. A status write with bit 0 = 1 sets the flag back to 1.
- R8: A serial mailbox update while the flag is 0 leaves the mailbox and the flag unchanged and sets the error bit.
- R9: A processor mailbox write while the flag is 1 leaves the mailbox unchanged and sets the error bit. A status write with bit 2 = 1 clears the error bit.
- R10: Holding trstN low, or reaching Test-Logic-Reset through TMS, selects BYPASS (4'b1111), sets the flag, and clears the pending bit, irq and the error bit.
- R11: During Shift-IR the instruction register shifts out the captured pattern 4'b0001, LSB first.
- R12: With BYPASS selected, the data path is one bit long, captured as 0, so TDO repeats TDI one TCK cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous system reset |
| tck | input | 1 | Serial test clock |
| tms | input | 1 | Test mode select, sampled on the TCK rising edge |
| tdi | input | 1 | Serial data in, sampled on the TCK rising edge |
| trstN | input | 1 | Active-low test reset |
| tdo | output | 1 | Serial data out, updated on the TCK falling edge |
| cpuSel | input | 1 | Processor access strobe |
| cpuWe | input | 1 | Write enable for the processor access |
| cpuAddr | input | 1 | 0 = status word, 1 = mailbox |
| cpuWdata | input | 32 | Processor write data |
| cpuRdata | output | 32 | Processor read data, combinational from cpuAddr |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A serial-side effect (irq, the flag, the error bit, a mailbox load) shows up about three clk cycles after the TCK rising edge that causes it: two synchroniser stages and one register. A new TDO bit appears about three clk cycles after a TCK falling edge. Processor writes are visible one clk cycle after the edge, and reads need no clock. The bench holds each TCK phase for eight clk cycles. It samples TDO just before each rising edge, and it reads processor-side results only after a full TCK phase, so every sample falls well after its result has settled.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_IRQ  = 4'b1010;
  localparam logic [IR_W-1:0] IR_STAT = 4'b0110;
  localparam logic [IR_W-1:0] IR_DATA = 4'b0111;
  localparam logic [IR_W-1:0] IR_BYP  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPT = 4'b0001;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  typedef struct packed {
    logic tapRst;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
    logic updDr;
    logic tdoLoad;
    logic tdoFromIr;
    logic tdiBit;
  } tapStrobe_t;
endpackage

// File: rtl/dbg_mailbox_tap.sv
module dbg_mailbox_tap
  import dbg_mailbox_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tck,
  input  logic       tms,
  input  logic       tdi,
  input  logic       trstN,
  output tapStrobe_t strb
);
  logic [SYNC_N-1:0] tckQ, tmsQ, tdiQ, trstQ;
  logic tckPrev, tckRise, tckFall, trstAct;
  tapState_e state;

  function automatic tapState_e nextOf(tapState_e s, logic m);
    case (s)
      TLR:    return m ? TLR    : RTI;
      RTI:    return m ? SEL_DR : RTI;
      SEL_DR: return m ? SEL_IR : CAP_DR;
      CAP_DR: return m ? EX1_DR : SH_DR;
      SH_DR:  return m ? EX1_DR : SH_DR;
      EX1_DR: return m ? UPD_DR : PAU_DR;
      PAU_DR: return m ? EX2_DR : PAU_DR;
      EX2_DR: return m ? UPD_DR : SH_DR;
      UPD_DR: return m ? SEL_DR : RTI;
      SEL_IR: return m ? TLR    : CAP_IR;
      CAP_IR: return m ? EX1_IR : SH_IR;
      SH_IR:  return m ? EX1_IR : SH_IR;
      EX1_IR: return m ? UPD_IR : PAU_IR;
      PAU_IR: return m ? EX2_IR : PAU_IR;
      EX2_IR: return m ? UPD_IR : SH_IR;
      UPD_IR: return m ? SEL_DR : RTI;
      default: return TLR;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tckQ    <= '0;
      tmsQ    <= '1;
      tdiQ    <= '0;
      trstQ   <= '0;
      tckPrev <= 1'b0;
    end else begin
      tckQ    <= {tckQ[SYNC_N-2:0], tck};
      tmsQ    <= {tmsQ[SYNC_N-2:0], tms};
      tdiQ    <= {tdiQ[SYNC_N-2:0], tdi};
      trstQ   <= {trstQ[SYNC_N-2:0], trstN};
      tckPrev <= tckQ[SYNC_N-1];
    end
  end

  assign tckRise = tckQ[SYNC_N-1] & ~tckPrev;
  assign tckFall = ~tckQ[SYNC_N-1] & tckPrev;
  assign trstAct = ~trstQ[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rstN || trstAct) state <= TLR;
    else if (tckRise)     state <= nextOf(state, tmsQ[SYNC_N-1]);
  end

  always_comb begin
    strb           = '0;
    strb.tapRst    = trstAct || (state == TLR);
    strb.capIr     = !trstAct && tckRise && (state == CAP_IR);
    strb.shIr      = !trstAct && tckRise && (state == SH_IR);
    strb.updIr     = !trstAct && tckRise && (state == UPD_IR);
    strb.capDr     = !trstAct && tckRise && (state == CAP_DR);
    strb.shDr      = !trstAct && tckRise && (state == SH_DR);
    strb.updDr     = !trstAct && tckRise && (state == UPD_DR);
    strb.tdoLoad   = tckFall && ((state == SH_DR) || (state == SH_IR));
    strb.tdoFromIr = (state == SH_IR);
    strb.tdiBit    = tdiQ[SYNC_N-1];
  end
endmodule

// File: rtl/dbg_mailbox_dp.sv
module dbg_mailbox_dp
  import dbg_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tapStrobe_t        strb,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic              cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              tdo,
  output logic              irq,
  output logic              readyFlag,
  output logic              errFlag
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IR_W-1:0]   ir, irShift;
  logic [DATA_W-1:0] drShift, drNext, mbx;
  logic [STAT_W-1:0] statWord;
  logic [IDX_W-1:0]  msbIdx;
  logic selData, selStat, pend, statWr, dataWr, serOk, serBad;

  assign selData  = (ir == IR_DATA);
  assign selStat  = (ir == IR_STAT);
  assign statWord = {{(STAT_W-3){1'b0}}, errFlag, pend, readyFlag};
  assign msbIdx   = selData ? IDX_W'(DATA_W-1) : selStat ? IDX_W'(STAT_W-1) : '0;
  assign statWr   = cpuSel && cpuWe && !cpuAddr;
  assign dataWr   = cpuSel && cpuWe && cpuAddr;
  assign serOk    = strb.updDr && selData && readyFlag;
  assign serBad   = strb.updDr && selData && !readyFlag;

  always_comb begin
    drNext         = {1'b0, drShift[DATA_W-1:1]};
    drNext[msbIdx] = strb.tdiBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.tapRst) begin
      ir      <= IR_BYP;
      irShift <= IR_CAPT;
    end else if (strb.capIr) irShift <= IR_CAPT;
    else if (strb.shIr)      irShift <= {strb.tdiBit, irShift[IR_W-1:1]};
    else if (strb.updIr)     ir      <= irShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              drShift <= '0;
    else if (strb.capDr)    drShift <= selData ? mbx :
                                       selStat ? {{(DATA_W-STAT_W){1'b0}}, statWord} : '0;
    else if (strb.shDr)     drShift <= drNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       mbx <= '0;
    else if (serOk)                  mbx <= drShift;
    else if (dataWr && !readyFlag)   mbx <= cpuWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.tapRst) begin
      readyFlag <= 1'b1;
      pend      <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (serOk)                        readyFlag <= 1'b0;
      else if (statWr && cpuWdata[0])   readyFlag <= 1'b1;
      if (strb.updIr && irShift == IR_IRQ) pend <= 1'b1;
      else if (statWr && cpuWdata[1])   pend <= 1'b0;
      if (serBad || (dataWr && readyFlag)) errFlag <= 1'b1;
      else if (statWr && cpuWdata[2])   errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.tapRst) tdo <= 1'b0;
    else if (strb.tdoLoad)    tdo <= strb.tdoFromIr ? irShift[0] : drShift[0];
  end

  assign irq      = pend;
  assign cpuRdata = cpuAddr ? mbx : {{(DATA_W-STAT_W){1'b0}}, statWord};
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trstN,
  output logic              tdo,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic              cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              irq
);
  tapStrobe_t strb;
  logic readyFlag, errFlag;

  dbg_mailbox_tap #(.SYNC_N(SYNC_N)) tap_i (
    .clk(clk), .rstN(rstN), .tck(tck), .tms(tms), .tdi(tdi),
    .trstN(trstN), .strb(strb)
  );

  dbg_mailbox_dp #(.DATA_W(DATA_W), .STAT_W(STAT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuSel(cpuSel), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .tdo(tdo),
    .irq(irq), .readyFlag(readyFlag), .errFlag(errFlag)
  );
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irq,
  input logic       readyFlag,
  input logic       errFlag,
  input logic       tapRst,
  input logic       updIr,
  input logic       updDr,
  input logic       cpuSel,
  input logic       cpuWe,
  input logic       cpuAddr,
  input logic [2:0] cpuWbits
);
  logic statWr, dataWr;
  assign statWr = cpuSel && cpuWe && !cpuAddr;
  assign dataWr = cpuSel && cpuWe && cpuAddr;

  assert_irq_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(updIr));

  assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !tapRst && !(statWr && cpuWbits[1])) |=> irq);

  assert_flag_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyFlag) |-> $past(updDr));

  assert_flag_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyFlag) |-> $past(tapRst || (statWr && cpuWbits[0])));

  assert_cpu_illegal_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && readyFlag && !tapRst) |=> errFlag);

  assert_tap_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    tapRst |=> (readyFlag && !irq && !errFlag));
endmodule

bind dbg_mailbox dbg_mailbox_chk chk_i (
  .clk(clk), .rstN(rstN), .irq(irq), .readyFlag(readyFlag), .errFlag(errFlag),
  .tapRst(strb.tapRst), .updIr(strb.updIr), .updDr(strb.updDr),
  .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWbits(cpuWdata[2:0])
);

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trstN = 1'b1;
  logic cpuSel = 1'b0, cpuWe = 1'b0, cpuAddr = 1'b0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic tdo, irq;
  int total = 0, bad = 0;

  typedef struct { string tag; logic [31:0] val; } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  dbg_mailbox dut_i (
    .clk(clk), .rstN(rstN), .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN),
    .tdo(tdo), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .irq(irq)
  );

  task automatic pushExp(input string tag, input logic [31:0] v);
    exp_t e;
    e.tag = tag; e.val = v;
    expQ.push_back(e);
  endtask

  task automatic observe(input logic [31:0] act);
    exp_t e;
    e = expQ.pop_front();
    total++;
    if (act !== e.val) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
    end
  endtask

  task automatic tckStep(input logic m, input logic d, output logic q);
    tms = m; tdi = d;
    repeat (8) @(negedge clk);
    q = tdo;
    tck = 1'b1;
    repeat (8) @(negedge clk);
    tck = 1'b0;
  endtask

  task automatic goIdle();
    logic q;
    for (int i = 0; i < 5; i++) tckStep(1'b1, 1'b0, q);
    tckStep(1'b0, 1'b0, q);
  endtask

  task automatic irScan(input logic [3:0] code, output logic [3:0] outv);
    logic q;
    tckStep(1'b1, 1'b0, q); tckStep(1'b1, 1'b0, q);
    tckStep(1'b0, 1'b0, q); tckStep(1'b0, 1'b0, q);
    for (int i = 0; i < 4; i++) begin
      tckStep(i == 3, code[i], q);
      outv[i] = q;
    end
    tckStep(1'b1, 1'b0, q); tckStep(1'b0, 1'b0, q);
  endtask

  task automatic drScan(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic q;
    dout = '0;
    tckStep(1'b1, 1'b0, q); tckStep(1'b0, 1'b0, q); tckStep(1'b0, 1'b0, q);
    for (int i = 0; i < n; i++) begin
      tckStep(i == n - 1, din[i], q);
      dout[i] = q;
    end
    tckStep(1'b1, 1'b0, q); tckStep(1'b0, 1'b0, q);
  endtask

  task automatic cpuWrite(input logic a, input logic [31:0] d);
    @(negedge clk);
    cpuSel = 1'b1; cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuSel = 1'b0; cpuWe = 1'b0; cpuWdata = '0;
    @(negedge clk);
  endtask

  task automatic cpuRead(input logic a, output logic [31:0] d);
    cpuAddr = a;
    @(negedge clk);
    d = cpuRdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, so;
    logic [3:0] io;
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    pushExp("R1 irq after reset", 0); observe({31'b0, irq});
    cpuRead(1'b0, rd);
    pushExp("R1 status after reset", 32'h1); observe(rd);
    goIdle();

    // R12 bypass path
    drScan(4, 32'hB, so);
    pushExp("R12 bypass one-bit delay", 32'h6); observe(so);

    // R11 and R2: interrupt instruction
    irScan(4'b1010, io);
    pushExp("R11 IR capture pattern", 32'h1); observe({28'b0, io});
    pushExp("R2 irq raised", 1); observe({31'b0, irq});

    // R4 status scan with pending set
    irScan(4'b0110, io);
    drScan(8, 32'h0, so);
    pushExp("R4 serial status", 32'h3); observe(so);

    // R3 interrupt clear
    pushExp("R3 irq held", 1); observe({31'b0, irq});
    cpuWrite(1'b0, 32'h2);
    pushExp("R3 irq cleared", 0); observe({31'b0, irq});
    cpuRead(1'b0, rd);
    pushExp("R3 status after clear", 32'h1); observe(rd);

    // R5 serial load, R6 capture of mailbox
    irScan(4'b0111, io);
    drScan(32, 32'hA5C31E69, so);
    pushExp("R6 captured mailbox at reset", 32'h0); observe(so);
    cpuRead(1'b1, rd);
    pushExp("R5 mailbox loaded", 32'hA5C31E69); observe(rd);
    cpuRead(1'b0, rd);
    pushExp("R5 flag cleared", 32'h0); observe(rd);

    // R7 processor owns mailbox
    cpuWrite(1'b1, 32'h12345678);
    cpuRead(1'b1, rd);
    pushExp("R7 cpu write accepted", 32'h12345678); observe(rd);
    cpuWrite(1'b0, 32'h1);
    cpuRead(1'b0, rd);
    pushExp("R7 flag returned", 32'h1); observe(rd);

    // R6 serial read-out of processor word
    drScan(32, 32'hFFFF0000, so);
    pushExp("R6 mailbox shifted out", 32'h12345678); observe(so);

    // R8 serial load while flag is 0
    drScan(32, 32'h0BADF00D, so);
    pushExp("R8 capture unchanged", 32'hFFFF0000); observe(so);
    cpuRead(1'b1, rd);
    pushExp("R8 mailbox unchanged", 32'hFFFF0000); observe(rd);
    cpuRead(1'b0, rd);
    pushExp("R8 error set", 32'h4); observe(rd);

    // R9 processor write while flag is 1
    cpuWrite(1'b0, 32'h4);
    cpuRead(1'b0, rd);
    pushExp("R9 error cleared", 32'h0); observe(rd);
    cpuWrite(1'b0, 32'h1);
    cpuWrite(1'b1, 32'h00000055);
    cpuRead(1'b1, rd);
    pushExp("R9 mailbox unchanged", 32'hFFFF0000); observe(rd);
    cpuRead(1'b0, rd);
    pushExp("R9 error set", 32'h5); observe(rd);
    cpuWrite(1'b0, 32'h4);

    // R10 trstN reset
    irScan(4'b1010, io);
    irScan(4'b0111, io);
    drScan(32, 32'h1, so);
    drScan(32, 32'h2, so);
    cpuRead(1'b0, rd);
    pushExp("R10 setup status", 32'h6); observe(rd);
    @(negedge clk); trstN = 1'b0;
    repeat (8) @(negedge clk); trstN = 1'b1;
    repeat (8) @(negedge clk);
    pushExp("R10 irq cleared by trstN", 0); observe({31'b0, irq});
    cpuRead(1'b0, rd);
    pushExp("R10 status after trstN", 32'h1); observe(rd);
    goIdle();
    drScan(2, 32'h3, so);
    pushExp("R10 bypass selected", 32'h2); observe(so);

    // R10 Test-Logic-Reset through TMS
    irScan(4'b1010, io);
    pushExp("R2 irq raised again", 1); observe({31'b0, irq});
    goIdle();
    pushExp("R10 irq cleared by TMS reset", 0); observe({31'b0, irq});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule